// File: doc/BRIEF.md
# Configurable Capture Timer/Counter

This block holds one pair of 8-bit counting lanes that a two-bit mode field maps onto four arrangements: two independent prescaled 8-bit timers, a prescaled 8-bit timer beside an 8-bit event counter, one prescaled 16-bit timer, or one 16-bit event counter. A shared 8-bit prescaler is a down-counter that reloads from a programmed value and issues a timer tick each time it reaches zero. Each timer or counter runs from zero up to a programmed limit, returns to zero on the next step and raises a sticky interrupt flag.

A rising edge on the capture strobe copies the live count of both lanes into a 16-bit capture register. The 16-bit capture register splits into two 8-bit halves. In the split modes each half belongs to its own lane. In the 16-bit modes the whole register holds the joined count. Capture never alters counting. The event and capture inputs are expected to be synchronous to the block clock already. Flags are cleared by a one-cycle write-clear pulse per flag.

Top module: `ctimer_capture`

## Requirements
- R1: After reset both capture halves read 0x00 and both interrupt flags read 0.
- R2: The prescaler starts at zero after reset or a mode change, gives a tick in every cycle in which it is zero, then loads `psc_reload_i`, and otherwise counts down by one, so ticks are `psc_reload_i`+1 cycles apart.
- R3: Mode 0 (`mode_i`=2'b00): the low lane and the high lane each advance by one on every tick. On a tick that finds a lane equal to its limit (`lim_lo_i` or `lim_hi_i`), that lane goes to zero and sets its own flag (`irq_lo_o` or `irq_hi_o`).
- R4: Mode 1 (2'b01): the low lane is a tick-driven timer as in R3. The high lane advances on each rising edge of `evt_i` (an edge is a cycle with `evt_i` high after a cycle with it low) and wraps against `lim_hi_i`, setting `irq_hi_o`.
- R5: Mode 2 (2'b10): the lanes form one 16-bit timer, with the high lane as bits 15:8. It advances on ticks, wraps against the limit {`lim_hi_i`,`lim_lo_i`} and sets only `irq_lo_o`. `irq_hi_o` is never newly set in this mode.
- R6: Mode 3 (2'b11): the lanes form one 16-bit counter of `evt_i` rising edges, with the same limit and flag as R5.
- R7: In a cycle that shows a rising edge of `cap_i`, `cap_hi_o`/`cap_lo_o` load the counts held at the start of that cycle, visible one cycle later. Holding `cap_i` high takes no further capture, and capture does not alter counting.
- R8: A set flag stays set until a cycle with its clear bit high (`flag_clr_i[0]` for `irq_lo_o`, `flag_clr_i[1]` for `irq_hi_o`). A flag set and a clear in the same cycle leave the flag set.
- R9: A cycle in which `mode_i` differs from the mode held since the last edge clears both lanes and the prescaler, and performs no counting. The flags and capture register keep their values, and the new mode takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Lane arrangement select |
| psc_reload_i | input | 8 | Prescaler reload value |
| lim_lo_i | input | 8 | Low lane limit, or bits 7:0 of the 16-bit limit |
| lim_hi_i | input | 8 | High lane limit, or bits 15:8 of the 16-bit limit |
| evt_i | input | 1 | External event level, synchronous |
| cap_i | input | 1 | Capture strobe, rising edge active |
| flag_clr_i | input | 2 | Per-flag clear pulse, bit 0 low flag, bit 1 high flag |
| cap_lo_o | output | 8 | Capture register bits 7:0 |
| cap_hi_o | output | 8 | Capture register bits 15:8 |
| irq_lo_o | output | 1 | Low lane or 16-bit match flag |
| irq_hi_o | output | 1 | High lane match flag |

## Verification
The bench forces limit matches to meet flag clears in the same cycle by using a reload of zero and a limit of zero, so a match occurs on every tick while the clear is held high. It judges that the flag never drops. The bench also lets capture edges land on wrap cycles and on mode-change cycles. A behavioural model compares the captured value with the pre-wrap or pre-clear count on every clock.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL8  = 2'b00,
    MODE_T8_EV8 = 2'b01,
    MODE_T16    = 2'b10,
    MODE_EV16   = 2'b11
  } ctimer_mode_e;
endpackage

// File: rtl/ctimer_presc.sv
module ctimer_presc #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [PW-1:0] reload_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= reload_i;
    else             cnt_q <= cnt_q - 1'b1;
  end

  a_r2_reload_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q == '0) |=> (cnt_q == $past(reload_i)));
  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> tick_o);
endmodule

// File: rtl/ctimer_edge.sv
module ctimer_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= 1'b0;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/ctimer_lane.sv
module ctimer_lane #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r3_clear_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/ctimer_capture.sv
module ctimer_capture #(
  parameter int HW = 8,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [PW-1:0] psc_reload_i,
  input  logic [HW-1:0] lim_lo_i,
  input  logic [HW-1:0] lim_hi_i,
  input  logic          evt_i,
  input  logic          cap_i,
  input  logic [1:0]    flag_clr_i,
  output logic [HW-1:0] cap_lo_o,
  output logic [HW-1:0] cap_hi_o,
  output logic          irq_lo_o,
  output logic          irq_hi_o
);
  import ctimer_pkg::*;

  localparam int FW = 2 * HW;

  ctimer_mode_e mode_q;
  logic         mode_chg;
  logic         wide;
  logic         psc_tick, tick, evt_stp;
  logic [1:0]   raw_in, rise;
  logic         step_lo, step_hi8;
  logic [HW-1:0] cnt_lo, cnt_hi;
  logic         hit_lo, hit_hi;
  logic         clr_lo, clr_hi, inc_lo, inc_hi;
  logic [1:0]   flag_set, flag_q;
  logic [FW-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_DUAL8;
    else         mode_q <= ctimer_mode_e'(mode_i);
  end

  assign mode_chg = (mode_i != mode_q);
  assign wide     = mode_q[1];

  ctimer_presc #(.PW(PW)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mode_chg),
    .reload_i(psc_reload_i),
    .tick_o  (psc_tick)
  );

  assign raw_in = {cap_i, evt_i};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    ctimer_edge u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_in[g]),
      .rise_o(rise[g])
    );
  end

  assign tick    = psc_tick & ~mode_chg;
  assign evt_stp = rise[0] & ~mode_chg;

  assign step_lo  = (mode_q == MODE_EV16)   ? evt_stp : tick;
  assign step_hi8 = (mode_q == MODE_T8_EV8) ? evt_stp : tick;

  // match is judged on the count before this step
  assign hit_lo = wide ? (step_lo & ({cnt_hi, cnt_lo} == {lim_hi_i, lim_lo_i}))
                       : (step_lo & (cnt_lo == lim_lo_i));
  assign hit_hi = ~wide & step_hi8 & (cnt_hi == lim_hi_i);

  assign clr_lo = mode_chg | hit_lo;
  assign inc_lo = step_lo & ~hit_lo;
  assign clr_hi = mode_chg | (wide ? hit_lo : hit_hi);
  assign inc_hi = wide ? (step_lo & ~hit_lo & (&cnt_lo)) : (step_hi8 & ~hit_hi);

  ctimer_lane #(.W(HW)) u_lane_lo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_lo),
    .inc_i (inc_lo),
    .cnt_o (cnt_lo)
  );

  ctimer_lane #(.W(HW)) u_lane_hi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_hi),
    .inc_i (inc_hi),
    .cnt_o (cnt_hi)
  );

  assign flag_set = {hit_hi, hit_lo};

  for (genvar f = 0; f < 2; f++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            flag_q[f] <= 1'b0;
      else if (flag_set[f])   flag_q[f] <= 1'b1;
      else if (flag_clr_i[f]) flag_q[f] <= 1'b0;
    end

    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[f] && !flag_clr_i[f]) |=> flag_q[f]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cap_q <= '0;
    else if (rise[1]) cap_q <= {cnt_hi, cnt_lo};
  end

  assign cap_lo_o = cap_q[HW-1:0];
  assign cap_hi_o = cap_q[FW-1:HW];
  assign irq_lo_o = flag_q[0];
  assign irq_hi_o = flag_q[1];

  a_r7_capture_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[1] |=> ({cap_hi_o, cap_lo_o} == $past({cnt_hi, cnt_lo})));
  a_r7_capture_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise[1] |=> $stable({cap_hi_o, cap_lo_o}));
  a_r9_mode_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (cnt_lo == '0 && cnt_hi == '0));
  a_r5_no_hi_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide && !irq_hi_o) |=> !irq_hi_o);
endmodule

// File: tb/ctimer_capture_tb_top.sv
module ctimer_capture_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] reload = 8'd0;
  logic [7:0] lim_lo = 8'd0, lim_hi = 8'd0;
  logic       evt = 1'b0, cap = 1'b0;
  logic [1:0] clr = 2'b00;
  logic [7:0] cap_lo, cap_hi;
  logic       irq_lo, irq_hi;

  int n_tot = 0, n_bad = 0;
  bit done = 0;
  string req = "R1";

  always #4 clk = ~clk;

  ctimer_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .psc_reload_i(reload),
    .lim_lo_i(lim_lo), .lim_hi_i(lim_hi), .evt_i(evt), .cap_i(cap),
    .flag_clr_i(clr), .cap_lo_o(cap_lo), .cap_hi_o(cap_hi),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  // behavioural reference
  int m_mode = 0, m_psc = 0, m_cnt = 0, m_lo = 0, m_hi = 0;
  int m_cap = 0;
  bit m_irq_lo = 0, m_irq_hi = 0, m_evt_q = 0, m_cap_q = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_psc = 0; m_lo = 0; m_hi = 0; m_cap = 0;
      m_irq_lo = 0; m_irq_hi = 0; m_evt_q = 0; m_cap_q = 0;
    end else begin
      bit tick, ev, ce, s_lo, s_hi;
      int lim16;
      ev = evt && !m_evt_q;
      ce = cap && !m_cap_q;
      s_lo = 0; s_hi = 0;
      if (ce) m_cap = m_hi * 256 + m_lo;
      if (int'(mode) != m_mode) begin
        m_mode = int'(mode); m_psc = 0; m_lo = 0; m_hi = 0;
      end else begin
        tick = (m_psc == 0);
        m_psc = tick ? int'(reload) : m_psc - 1;
        lim16 = int'(lim_hi) * 256 + int'(lim_lo);
        if (m_mode < 2) begin
          if (tick) begin
            if (m_lo == int'(lim_lo)) begin m_lo = 0; s_lo = 1; end
            else m_lo = (m_lo + 1) % 256;
          end
          if ((m_mode == 0) ? tick : ev) begin
            if (m_hi == int'(lim_hi)) begin m_hi = 0; s_hi = 1; end
            else m_hi = (m_hi + 1) % 256;
          end
        end else if ((m_mode == 2) ? tick : ev) begin
          m_cnt = m_hi * 256 + m_lo;
          if (m_cnt == lim16) begin m_cnt = 0; s_lo = 1; end
          else m_cnt = (m_cnt + 1) % 65536;
          m_lo = m_cnt % 256; m_hi = m_cnt / 256;
        end
      end
      if (s_lo) m_irq_lo = 1; else if (clr[0]) m_irq_lo = 0;
      if (s_hi) m_irq_hi = 1; else if (clr[1]) m_irq_hi = 0;
      m_evt_q = evt; m_cap_q = cap;
    end
  end

  task automatic step();
    @(negedge clk);
    n_tot++;
    if (cap_lo !== 8'(m_cap % 256) || cap_hi !== 8'(m_cap / 256) ||
        irq_lo !== m_irq_lo || irq_hi !== m_irq_hi) begin
      n_bad++;
      $display("FAIL %s t=%0t: cap=%h%h irq=%b%b expected cap=%h%h irq=%b%b",
               req, $time, cap_hi, cap_lo, irq_hi, irq_lo,
               8'(m_cap / 256), 8'(m_cap % 256), m_irq_hi, m_irq_lo);
    end
  endtask

  task automatic run_rand(input int n, input int cap_every, input bit rnd_evt);
    for (int i = 0; i < n; i++) begin
      step();
      cap = (cap_every != 0) && ((i % cap_every) < 2);
      if (rnd_evt) evt = 1'($urandom_range(0, 1));
      clr = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
    end
    cap = 0; clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    step();
    rst_n = 1'b1;
    step(); step();

    // R2 R3: dual 8-bit timers, prescaler period reload+1
    req = "R2/R3";
    reload = 8'd2; lim_lo = 8'd5; lim_hi = 8'd3;
    run_rand(120, 7, 0);

    // R8: match meets clear in the same cycle, set must win
    req = "R8";
    reload = 8'd0; lim_lo = 8'd0; lim_hi = 8'd0;
    for (int i = 0; i < 20; i++) begin step(); clr = 2'b11; end
    clr = 2'b00;
    lim_lo = 8'd200; lim_hi = 8'd200;
    step(); step(); clr = 2'b11; step(); clr = 2'b00; step(); step();

    // R4: timer plus event counter
    req = "R4";
    mode = 2'b01; reload = 8'd1; lim_lo = 8'd9; lim_hi = 8'd4;
    run_rand(200, 5, 1);

    // R5: 16-bit prescaled timer across the byte carry
    req = "R5";
    mode = 2'b10; reload = 8'd0; lim_lo = 8'h05; lim_hi = 8'h01;
    run_rand(700, 23, 0);

    // R6: 16-bit event counter
    req = "R6";
    mode = 2'b11; lim_lo = 8'h10; lim_hi = 8'h00;
    run_rand(300, 11, 1);

    // R7: held strobe takes a single capture
    req = "R7";
    evt = 0; mode = 2'b10; lim_lo = 8'hFF; lim_hi = 8'hFF;
    step(); cap = 1;
    for (int i = 0; i < 30; i++) step();
    cap = 0;
    step(); cap = 1; step(); cap = 0; step(); step();

    // R9: mode change clears counts, capture on the change cycle sees old count
    req = "R9";
    mode = 2'b00; cap = 1; step(); cap = 0; step();
    cap = 1; step(); cap = 0; step(); step();
    mode = 2'b01; step(); mode = 2'b10; step(); mode = 2'b11; step();
    run_rand(60, 9, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end
endmodule